// File: doc/BRIEF.md
# Timestamped Priority Bus Arbiter

This block shares one bus among several request queues. It serves one queue per cache plus one for main memory. It sees only the head entry of each queue. Every head carries five things: a valid flag, an earliest-service timestamp, a 3-bit operation code, an address and a destination port index. The arbiter keeps its own free-running cycle counter. In each cycle it treats a head as eligible only when the head's timestamp has already been reached.

Among the eligible heads, the winner is chosen by operation class and not by requester. A write-back of dirty data beats an update broadcast, and an update broadcast beats everything else. Heads in the same class are served in round-robin order of requester index, so no queue starves. The winning queue gets a dequeue pulse in the same cycle. On the next clock edge the message appears on the bus outputs for exactly one cycle, tagged with the index of its source.

The control is a two-state machine. S_IDLE means no message is on the bus. S_XFER means a message is being delivered this cycle. The machine takes the transition GRANT (S_IDLE or S_XFER to S_XFER) in any cycle in which some head is eligible. It takes the transition DRAIN (S_XFER or S_IDLE to S_IDLE) in any cycle in which no head is eligible.

Top module: `tsq_bus_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_vld` is 0 and `now_cycle` is 0. With no valid head, `deq` is all zeros.
- R2: `now_cycle` increases by exactly one on every clock edge out of reset, wrapping at its width.
- R3: A head whose timestamp is greater than `now_cycle` is never dequeued. A head whose timestamp equals `now_cycle` is eligible.
- R4: When exactly one head is eligible, its `deq` bit is 1 in that same cycle.
- R5: Operation code 5 (write-back flush) wins over every other eligible code.
- R6: Operation code 4 (update broadcast) wins over every code other than 5.
- R7: Codes 6 (reply), 2 (shared read) and 3 (exclusive read) form the lowest class. Every other code (0 load, 1 store, 7) is also placed in it.
- R8: Within the winning class, the search starts at the index one above the last granted requester and wraps past the top index. Before the first grant it starts at 0.
- R9: At most one `deq` bit is set per cycle. None is set when no head is eligible.
- R10: One cycle after a dequeue, `bus_vld` is 1 for that cycle only, unless another dequeue follows. `bus_op`, `bus_addr` and `bus_dst` carry the granted head's fields, and `bus_src` carries its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N_REQ | Head-valid flag per queue |
| req_ts | input | N_REQ*TS_W | Earliest-service cycle per head, queue i at bits [i*TS_W +: TS_W] |
| req_op | input | N_REQ*3 | Operation code per head |
| req_addr | input | N_REQ*ADDR_W | Block address per head |
| req_dst | input | N_REQ*PORT_W | Destination port per head |
| deq | output | N_REQ | One-hot dequeue of the granted head, same cycle |
| now_cycle | output | TS_W | Current cycle counter |
| bus_vld | output | 1 | Bus delivery strobe, high in S_XFER |
| bus_op | output | 3 | Delivered operation |
| bus_addr | output | ADDR_W | Delivered address |
| bus_src | output | PORT_W | Index of the queue that sent the message |
| bus_dst | output | PORT_W | Destination port of the message |

## Verification
The bench builds the block with three requesters, a 16-bit timestamp and a 12-bit address. Three requesters make class collisions and round-robin wraparound happen often, both in the directed cases and under random timestamps. The random heads use timestamps from two cycles in the past to four cycles in the future, so eligibility changes in almost every cycle. The directed cases cover the exact boundary where the timestamp equals the counter, a full three-class contest, and a tie between a load code and a reply.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_RD     = 3'd2,
        OP_RDX    = 3'd3,
        OP_UPD    = 3'd4,
        OP_FLUSH  = 3'd5,
        OP_REPLY  = 3'd6,
        OP_RSVD   = 3'd7
    } bus_op_e;

    typedef enum logic [1:0] {
        CLS_LOW   = 2'd0,
        CLS_UPD   = 2'd1,
        CLS_FLUSH = 2'd2
    } op_cls_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_XFER = 1'b1
    } arb_state_e;

    // Priority class of an operation; unknown codes fall into the lowest class.
    function automatic op_cls_e op_class(input logic [OP_W-1:0] op);
        op_cls_e c;
        unique case (op)
            OP_FLUSH: c = CLS_FLUSH;
            OP_UPD:   c = CLS_UPD;
            default:  c = CLS_LOW;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tsq_elig.sv
module tsq_elig
    import tsq_pkg::*;
#(
    parameter int N_REQ = 5,
    parameter int TS_W  = 16
) (
    input  logic [N_REQ-1:0]      vld,
    input  logic [N_REQ*TS_W-1:0] ts,
    input  logic [N_REQ*OP_W-1:0] op,
    input  logic [TS_W-1:0]       now,
    output logic [N_REQ-1:0]      m_flush,
    output logic [N_REQ-1:0]      m_upd,
    output logic [N_REQ-1:0]      m_low
);
    // Per-head eligibility and class sorting, one slice per requester.
    for (genvar i = 0; i < N_REQ; i++) begin : g_head
        logic    ready;
        op_cls_e cls;
        assign ready = vld[i] && (ts[i*TS_W +: TS_W] <= now);
        assign cls   = op_class(op[i*OP_W +: OP_W]);
        assign m_flush[i] = ready && (cls == CLS_FLUSH);
        assign m_upd[i]   = ready && (cls == CLS_UPD);
        assign m_low[i]   = ready && (cls == CLS_LOW);
    end
endmodule

// File: rtl/tsq_class_sel.sv
module tsq_class_sel #(
    parameter int N_REQ = 5
) (
    input  logic [N_REQ-1:0] m_flush,
    input  logic [N_REQ-1:0] m_upd,
    input  logic [N_REQ-1:0] m_low,
    output logic [N_REQ-1:0] win_mask,
    output logic             any
);
    // Keep only the highest non-empty class.
    always_comb begin
        if (|m_flush)      win_mask = m_flush;
        else if (|m_upd)   win_mask = m_upd;
        else               win_mask = m_low;
        any = |win_mask;
    end
endmodule

// File: rtl/tsq_rr_pick.sv
module tsq_rr_pick #(
    parameter int N_REQ = 5,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] mask,
    input  logic [IDX_W-1:0] ptr,
    output logic [N_REQ-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // First set bit at or above ptr, wrapping past the top index.
    always_comb begin
        int j;
        grant = '0;
        idx   = '0;
        found = 1'b0;
        for (int k = 0; k < N_REQ; k++) begin
            j = int'(ptr) + k;
            if (j >= N_REQ) j = j - N_REQ;
            if (!found && mask[j]) begin
                found    = 1'b1;
                grant[j] = 1'b1;
                idx      = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/tsq_bus_arbiter.sv
module tsq_bus_arbiter
    import tsq_pkg::*;
#(
    parameter int N_REQ  = 5,
    parameter int TS_W   = 16,
    parameter int ADDR_W = 32,
    localparam int PORT_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req_vld,
    input  logic [N_REQ*TS_W-1:0]   req_ts,
    input  logic [N_REQ*OP_W-1:0]   req_op,
    input  logic [N_REQ*ADDR_W-1:0] req_addr,
    input  logic [N_REQ*PORT_W-1:0] req_dst,
    output logic [N_REQ-1:0]        deq,
    output logic [TS_W-1:0]         now_cycle,
    output logic                    bus_vld,
    output logic [OP_W-1:0]         bus_op,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [PORT_W-1:0]       bus_src,
    output logic [PORT_W-1:0]       bus_dst
);
    localparam logic [PORT_W-1:0] LAST_IDX = PORT_W'(N_REQ - 1);

    arb_state_e        state_q, state_d;
    logic [TS_W-1:0]   cnt_q;
    logic [PORT_W-1:0] ptr_q;
    logic [N_REQ-1:0]  m_flush, m_upd, m_low, win_mask, grant;
    logic [PORT_W-1:0] g_idx;
    logic              any_elig, found;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PORT_W-1:0] src_q, dst_q;

    tsq_elig #(.N_REQ(N_REQ), .TS_W(TS_W)) u_elig (
        .vld(req_vld), .ts(req_ts), .op(req_op), .now(cnt_q),
        .m_flush(m_flush), .m_upd(m_upd), .m_low(m_low)
    );

    tsq_class_sel #(.N_REQ(N_REQ)) u_cls (
        .m_flush(m_flush), .m_upd(m_upd), .m_low(m_low),
        .win_mask(win_mask), .any(any_elig)
    );

    tsq_rr_pick #(.N_REQ(N_REQ)) u_rr (
        .mask(win_mask), .ptr(ptr_q),
        .grant(grant), .idx(g_idx), .found(found)
    );

    // Next-state logic: GRANT when a head is eligible, DRAIN otherwise.
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = (any_elig && found) ? S_XFER : S_IDLE;
            S_XFER:  state_d = (any_elig && found) ? S_XFER : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Cycle counter, round-robin pointer and captured message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ptr_q  <= '0;
            op_q   <= '0;
            addr_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
        end else begin
            cnt_q <= cnt_q + TS_W'(1);
            if (state_d == S_XFER) begin
                ptr_q  <= (g_idx == LAST_IDX) ? '0 : g_idx + PORT_W'(1);
                op_q   <= req_op[g_idx*OP_W +: OP_W];
                addr_q <= req_addr[g_idx*ADDR_W +: ADDR_W];
                src_q  <= g_idx;
                dst_q  <= req_dst[g_idx*PORT_W +: PORT_W];
            end
        end
    end

    // Output process.
    always_comb begin
        deq       = (state_d == S_XFER) ? grant : '0;
        now_cycle = cnt_q;
        bus_vld   = (state_q == S_XFER);
        bus_op    = op_q;
        bus_addr  = addr_q;
        bus_src   = src_q;
        bus_dst   = dst_q;
    end
endmodule

// File: rtl/tsq_bus_arbiter_chk.sv
module tsq_bus_arbiter_chk
    import tsq_pkg::*;
#(
    parameter int N_REQ  = 5,
    parameter int TS_W   = 16,
    parameter int ADDR_W = 32,
    localparam int PORT_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_REQ-1:0]        req_vld,
    input logic [N_REQ*TS_W-1:0]   req_ts,
    input logic [N_REQ*OP_W-1:0]   req_op,
    input logic [N_REQ-1:0]        deq,
    input logic [TS_W-1:0]         now_cycle,
    input logic                    bus_vld,
    input logic [OP_W-1:0]         bus_op,
    input logic [PORT_W-1:0]       bus_src
);
    logic [N_REQ-1:0] rdy, rdy_fl, rdy_up;
    for (genvar i = 0; i < N_REQ; i++) begin : g_c
        assign rdy[i]    = req_vld[i] && (req_ts[i*TS_W +: TS_W] <= now_cycle);
        assign rdy_fl[i] = rdy[i] && (req_op[i*OP_W +: OP_W] == OP_FLUSH);
        assign rdy_up[i] = rdy[i] && (req_op[i*OP_W +: OP_W] == OP_UPD);

        p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
            deq[i] |-> rdy[i]);
    end

    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> now_cycle == TS_W'($past(now_cycle) + TS_W'(1)));

    p_one_deq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deq));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy == '0) |-> (deq == '0));

    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rdy) == 1) |-> (deq == rdy));

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_fl != '0) |=> (bus_vld && bus_op == OP_FLUSH));

    p_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_fl == '0 && rdy_up != '0) |=> (bus_vld && bus_op == OP_UPD));

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deq == '0) |=> !bus_vld);

    p_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld |-> ($past(deq) == (N_REQ'(1) << bus_src)));
endmodule

bind tsq_bus_arbiter tsq_bus_arbiter_chk #(
    .N_REQ(N_REQ), .TS_W(TS_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ts(req_ts),
    .req_op(req_op), .deq(deq), .now_cycle(now_cycle), .bus_vld(bus_vld),
    .bus_op(bus_op), .bus_src(bus_src)
);

// File: tb/tb_tsq_bus_arbiter.sv
module tb_tsq_bus_arbiter;
    localparam int NR = 3;
    localparam int TW = 16;
    localparam int AW = 12;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_vld;
    logic [NR*TW-1:0] req_ts;
    logic [NR*3-1:0]  req_op;
    logic [NR*AW-1:0] req_addr;
    logic [NR*PW-1:0] req_dst;
    logic [NR-1:0]    deq;
    logic [TW-1:0]    now_cycle;
    logic             bus_vld;
    logic [2:0]       bus_op;
    logic [AW-1:0]    bus_addr;
    logic [PW-1:0]    bus_src, bus_dst;

    always #2 clk = ~clk;

    tsq_bus_arbiter #(.N_REQ(NR), .TS_W(TW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ts(req_ts),
        .req_op(req_op), .req_addr(req_addr), .req_dst(req_dst), .deq(deq),
        .now_cycle(now_cycle), .bus_vld(bus_vld), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_src(bus_src), .bus_dst(bus_dst)
    );

    // Model of the queue heads.
    logic          hv  [NR];
    logic [TW-1:0] hts [NR];
    logic [2:0]    hop [NR];
    logic [AW-1:0] had [NR];
    logic [PW-1:0] hds [NR];
    int mptr, cyc, n_chk, n_fail;
    bit done;
    logic          e_vld;
    logic [2:0]    e_op;
    logic [AW-1:0] e_addr;
    logic [PW-1:0] e_src, e_dst;

    function automatic int cls(input logic [2:0] op);
        return (op == 3'd5) ? 2 : (op == 3'd4) ? 1 : 0;
    endfunction

    function automatic int model_pick();
        for (int c = 2; c >= 0; c--)
            for (int k = 0; k < NR; k++) begin
                int j = (mptr + k) % NR;
                if (hv[j] && int'(hts[j]) <= cyc && cls(hop[j]) == c) return j;
            end
        return -1;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
        end
    endtask

    task automatic set_head(input int i, input logic v, input int ts, input logic [2:0] op);
        hv[i] = v; hts[i] = TW'(ts); hop[i] = op;
        had[i] = AW'($urandom); hds[i] = PW'($urandom % NR);
    endtask

    task automatic apply();
        for (int i = 0; i < NR; i++) begin
            req_vld[i] = hv[i];
            req_ts[i*TW +: TW] = hts[i];
            req_op[i*3 +: 3] = hop[i];
            req_addr[i*AW +: AW] = had[i];
            req_dst[i*PW +: PW] = hds[i];
        end
    endtask

    // One cycle: called at a negedge. refill: replace popped or idle heads randomly.
    task automatic step(input string tag, input bit refill);
        int g;
        logic [NR-1:0] exp_deq;
        apply();
        #1;
        g = model_pick();
        exp_deq = (g >= 0) ? NR'(1) << g : '0;
        check((g < 0) ? "R9" : tag, 64'(deq), 64'(exp_deq));
        e_vld = (g >= 0);
        if (g >= 0) begin
            e_op = hop[g]; e_addr = had[g]; e_src = PW'(g); e_dst = hds[g];
            mptr = (g + 1) % NR;
            hv[g] = 1'b0;
        end
        @(negedge clk);
        cyc++;
        check("R2", 64'(now_cycle), 64'(cyc));
        check("R10", 64'(bus_vld), 64'(e_vld));
        if (e_vld) begin
            check("R10", 64'({bus_op, bus_addr, bus_src, bus_dst}),
                  64'({e_op, e_addr, e_src, e_dst}));
        end
        if (refill)
            for (int i = 0; i < NR; i++)
                if (!hv[i] && ($urandom % 4 != 0)) begin
                    logic [2:0] op;
                    int base = (cyc >= 2) ? cyc - 2 : 0;
                    op = ($urandom % 8 == 0) ? 3'(($urandom % 2)) : 3'(2 + $urandom % 5);
                    set_head(i, 1'b1, base + int'($urandom % 7), op);
                end
    endtask

    initial begin
        void'($urandom(32'd4242));
        n_chk = 0; n_fail = 0; mptr = 0; cyc = 0; done = 0;
        for (int i = 0; i < NR; i++) set_head(i, 1'b0, 0, 3'd2);
        apply();
        repeat (3) @(posedge clk);
        #1;
        check("R1", 64'(bus_vld), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 64'(now_cycle), 64'(0));
        check("R1", 64'(deq), 64'(0));

        // R3: future timestamp is held back; equal timestamp is eligible (R4).
        set_head(0, 1'b1, cyc + 2, 3'd2);
        step("R3", 0);
        check("R3", 64'(hv[0]), 64'(1));
        step("R3", 0);
        step("R4", 0);
        check("R4", 64'(hv[0]), 64'(0));

        // R5/R6/R7: three classes contend.
        set_head(0, 1'b1, cyc, 3'd6);
        set_head(1, 1'b1, cyc, 3'd4);
        set_head(2, 1'b1, 0, 3'd5);
        step("R5", 0);
        step("R6", 0);
        step("R7", 0);

        // R8: round-robin rotation among equal-class reads.
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < NR; i++)
                if (!hv[i]) set_head(i, 1'b1, cyc, (i == 1) ? 3'd3 : 3'd2);
            step("R8", 0);
        end

        // R7: load code ties with a reply.
        set_head(0, 1'b1, cyc, 3'd0);
        set_head(1, 1'b0, 0, 3'd2);
        set_head(2, 1'b1, cyc, 3'd6);
        step("R7", 0);
        step("R7", 0);
        step("R9", 0);

        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            int g0 = model_pick();
            string tg = (g0 < 0) ? "R9" : (cls(hop[g0]) == 2) ? "R5" :
                        (cls(hop[g0]) == 1) ? "R6" : "R8";
            step(tg, 1);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule